// File: doc/BRIEF.md
# ECC Error Logging and Check-Bit Injection

This block sits next to the SECDED datapath of a memory controller. The decoder reports two kinds of event: corrected and uncorrected. Each event carries a 32-bit byte address, an 8-bit syndrome and the 64-bit data word. For each kind, the block latches the details of the first event into readable registers and sets a pending flag. Any pending flag raises a level interrupt. A further event of the same kind that arrives before software clears the flag leaves the latched details untouched and sets a separate repeat flag. Software clears flags by writing ones to an acknowledge register.

An option register holds the two-bit ECC mode. Logging takes place only in the enabled modes. The same register also holds a one-shot forced-check request and an 8-bit pattern. While the request is set, the next memory write has the pattern XORed into its check bits, and the request then clears itself. This lets software inject errors on purpose.

The register bus is a plain single-cycle strobe interface with registered read data. The error window and the interrupt window sit at parameterised base addresses.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the interrupt status, the option register and the interrupt output are all zero.
- R2: With option mode bits 1:0 equal to 0 or 2, events are not logged: the status stays zero. Modes 1 and 3 log events.
- R3: A corrected event, with corrected status bit 3 clear, sets bit 3 of interrupt status (window offset 0x00). It also captures the address at error offset 0x18, the syndrome in bits 15:8 of offset 0x1C, data bits 31:0 at 0x20 and data bits 63:32 at 0x24.
- R4: An uncorrected event, with status bit 5 clear, sets bit 5. It captures the address at 0x08, the syndrome in bits 15:8 of 0x0C, and the data low and high words at 0x10 and 0x14.
- R5: An event of a class whose first flag is already set sets that class's repeat bit (bit 4 for corrected, bit 6 for uncorrected) and leaves the captured registers unchanged.
- R6: Writing to the acknowledge register (interrupt offset 0x04) clears every status bit where the written value has a one. A cleared class captures again on its next event.
- R7: The interrupt output is high exactly while any of status bits 6:3 is set. It follows an event or an acknowledge one clock later.
- R8: A corrected and an uncorrected event in the same cycle are both logged, each in its own class registers.
- R9: The option register (error offset 0x00) stores mode in bits 1:0, the forced-check request in bit 8 and the pattern in bits 23:16. All other bits read as zero.
- R10: The check-bit output equals the check-bit input XOR the pattern only on a write strobe while the request bit is set. That write clears the request. The pattern has no effect while the request is clear.
- R11: When an acknowledge of a class's first bit and an event of that class fall in the same cycle, the acknowledge is applied first. The event is then captured as a new first error, with no repeat bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and logging clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| ce_valid | input | 1 | Corrected event strobe |
| ce_addr | input | 32 | Corrected event byte address |
| ce_syndrome | input | 8 | Corrected event syndrome |
| ce_data | input | 64 | Corrected event data word |
| ue_valid | input | 1 | Uncorrected event strobe |
| ue_addr | input | 32 | Uncorrected event byte address |
| ue_syndrome | input | 8 | Uncorrected event syndrome |
| ue_data | input | 64 | Uncorrected event data word |
| wr_valid | input | 1 | Memory write strobe from the datapath |
| chk_in | input | CHK_W | Encoder check bits for that write |
| chk_out | output | CHK_W | Check bits after optional injection |
| irq | output | 1 | Level interrupt |

## Verification
Status flags, captured registers and the interrupt change on the first clock edge after the event or acknowledge strobe. A read returns data on the edge that samples the read strobe, so a read issued in the cycle after an event already sees the event. The check-bit output is combinational, so it is checked in the same cycle as the write strobe. The request clearing is seen by a read issued after that edge. The bench drives inputs on the falling edge and samples one time unit after the rising edge, which places every comparison in the cycle these latencies predict.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int ECC_ADDR_W = 32;
    localparam int ECC_SYND_W = 8;
    localparam int ECC_DATA_W = 64;

    // error window offsets
    localparam int OFS_OPTION  = 'h00;
    localparam int OFS_UE_ADDR = 'h08;
    localparam int OFS_UE_STAT = 'h0C;
    localparam int OFS_UE_DLO  = 'h10;
    localparam int OFS_UE_DHI  = 'h14;
    localparam int OFS_CE_ADDR = 'h18;
    localparam int OFS_CE_STAT = 'h1C;
    localparam int OFS_CE_DLO  = 'h20;
    localparam int OFS_CE_DHI  = 'h24;

    // interrupt window offsets
    localparam int OFS_INT_STAT = 'h00;
    localparam int OFS_INT_ACK  = 'h04;

    // status bit positions; class g uses FIRST_LSB+2g and FIRST_LSB+2g+1
    localparam int STAT_FIRST_LSB = 3;
    localparam int NUM_CLASS      = 2;   // 0 corrected, 1 uncorrected

    // option fields
    localparam int OPT_FWC_BIT = 8;
    localparam int OPT_PAT_LSB = 16;
    localparam int SYND_LSB    = 8;

    function automatic logic mode_logs(input logic [1:0] mode);
        return mode[0];
    endfunction
endpackage

// File: rtl/ecc_class_log.sv
module ecc_class_log
    import ecc_log_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  log_en,
    input  logic                  evt_valid,
    input  logic [ECC_ADDR_W-1:0] evt_addr,
    input  logic [ECC_SYND_W-1:0] evt_synd,
    input  logic [ECC_DATA_W-1:0] evt_data,
    input  logic                  clr_first,
    input  logic                  clr_rep,
    output logic                  first_q,
    output logic                  rep_q,
    output logic [ECC_ADDR_W-1:0] addr_q,
    output logic [ECC_SYND_W-1:0] synd_q,
    output logic [ECC_DATA_W-1:0] data_q
);
    typedef struct packed {
        logic                  first;
        logic                  rep;
        logic [ECC_ADDR_W-1:0] addr;
        logic [ECC_SYND_W-1:0] synd;
        logic [ECC_DATA_W-1:0] data;
    } cls_st_t;

    cls_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.first = st_q.first & ~clr_first;
        st_d.rep   = st_q.rep & ~clr_rep;
        if (log_en && evt_valid) begin
            if (st_d.first) begin
                st_d.rep = 1'b1;
            end else begin
                st_d.first = 1'b1;
                st_d.addr  = evt_addr;
                st_d.synd  = evt_synd;
                st_d.data  = evt_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_q = st_q.first;
    assign rep_q   = st_q.rep;
    assign addr_q  = st_q.addr;
    assign synd_q  = st_q.synd;
    assign data_q  = st_q.data;
endmodule

// File: rtl/ecc_opt_inject.sv
module ecc_opt_inject
    import ecc_log_pkg::*;
#(
    parameter int CHK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_wr,
    input  logic [1:0]       wr_mode,
    input  logic             wr_fwc,
    input  logic [CHK_W-1:0] wr_pat,
    input  logic             wr_valid,
    input  logic [CHK_W-1:0] chk_in,
    output logic [CHK_W-1:0] chk_out,
    output logic [1:0]       mode_q,
    output logic             fwc_q,
    output logic [CHK_W-1:0] pat_q
);
    typedef struct packed {
        logic [1:0]       mode;
        logic             fwc;
        logic [CHK_W-1:0] pat;
    } opt_st_t;

    opt_st_t opt_d, opt_q;
    logic    inject;

    assign inject = opt_q.fwc && wr_valid;

    always_comb begin
        opt_d = opt_q;
        if (inject) opt_d.fwc = 1'b0;
        if (opt_wr) begin
            opt_d.mode = wr_mode;
            opt_d.fwc  = wr_fwc;
            opt_d.pat  = wr_pat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) opt_q <= '0;
        else        opt_q <= opt_d;
    end

    assign chk_out = inject ? (chk_in ^ opt_q.pat) : chk_in;
    assign mode_q  = opt_q.mode;
    assign fwc_q   = opt_q.fwc;
    assign pat_q   = opt_q.pat;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int                REG_AW   = 12,
    parameter logic [REG_AW-1:0] ERR_BASE = 12'h100,
    parameter logic [REG_AW-1:0] INT_BASE = 12'h200,
    parameter int                CHK_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  ce_valid,
    input  logic [ECC_ADDR_W-1:0] ce_addr,
    input  logic [ECC_SYND_W-1:0] ce_syndrome,
    input  logic [ECC_DATA_W-1:0] ce_data,
    input  logic                  ue_valid,
    input  logic [ECC_ADDR_W-1:0] ue_addr,
    input  logic [ECC_SYND_W-1:0] ue_syndrome,
    input  logic [ECC_DATA_W-1:0] ue_data,
    input  logic                  wr_valid,
    input  logic [CHK_W-1:0]      chk_in,
    output logic [CHK_W-1:0]      chk_out,
    output logic                  irq
);
    localparam int STAT_TOP = STAT_FIRST_LSB + 2*NUM_CLASS - 1;

    logic [REG_AW-1:0] a_opt, a_int_stat, a_int_ack;
    assign a_opt      = ERR_BASE + REG_AW'(OFS_OPTION);
    assign a_int_stat = INT_BASE + REG_AW'(OFS_INT_STAT);
    assign a_int_ack  = INT_BASE + REG_AW'(OFS_INT_ACK);

    logic opt_wr, ack_wr;
    assign opt_wr = reg_wr_en && (reg_addr == a_opt);
    assign ack_wr = reg_wr_en && (reg_addr == a_int_ack);

    // option register and check-bit injection
    logic [1:0]       mode_q;
    logic             fwc;
    logic [CHK_W-1:0] pat_q;
    logic             ecc_on;

    ecc_opt_inject #(.CHK_W(CHK_W)) u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .opt_wr   (opt_wr),
        .wr_mode  (reg_wdata[1:0]),
        .wr_fwc   (reg_wdata[OPT_FWC_BIT]),
        .wr_pat   (reg_wdata[OPT_PAT_LSB +: CHK_W]),
        .wr_valid (wr_valid),
        .chk_in   (chk_in),
        .chk_out  (chk_out),
        .mode_q   (mode_q),
        .fwc_q    (fwc),
        .pat_q    (pat_q)
    );

    assign ecc_on = mode_logs(mode_q);

    // per-class logging
    logic                  ev_valid  [NUM_CLASS];
    logic [ECC_ADDR_W-1:0] ev_addr   [NUM_CLASS];
    logic [ECC_SYND_W-1:0] ev_synd   [NUM_CLASS];
    logic [ECC_DATA_W-1:0] ev_data   [NUM_CLASS];
    logic                  cls_first [NUM_CLASS];
    logic                  cls_rep   [NUM_CLASS];
    logic [ECC_ADDR_W-1:0] cls_addr  [NUM_CLASS];
    logic [ECC_SYND_W-1:0] cls_synd  [NUM_CLASS];
    logic [ECC_DATA_W-1:0] cls_data  [NUM_CLASS];

    assign ev_valid[0] = ce_valid;
    assign ev_addr[0]  = ce_addr;
    assign ev_synd[0]  = ce_syndrome;
    assign ev_data[0]  = ce_data;
    assign ev_valid[1] = ue_valid;
    assign ev_addr[1]  = ue_addr;
    assign ev_synd[1]  = ue_syndrome;
    assign ev_data[1]  = ue_data;

    logic [STAT_TOP:STAT_FIRST_LSB] int_stat;

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
        ecc_class_log u_cls (
            .clk       (clk),
            .rst_n     (rst_n),
            .log_en    (ecc_on),
            .evt_valid (ev_valid[g]),
            .evt_addr  (ev_addr[g]),
            .evt_synd  (ev_synd[g]),
            .evt_data  (ev_data[g]),
            .clr_first (ack_wr && reg_wdata[STAT_FIRST_LSB + 2*g]),
            .clr_rep   (ack_wr && reg_wdata[STAT_FIRST_LSB + 2*g + 1]),
            .first_q   (cls_first[g]),
            .rep_q     (cls_rep[g]),
            .addr_q    (cls_addr[g]),
            .synd_q    (cls_synd[g]),
            .data_q    (cls_data[g])
        );
        assign int_stat[STAT_FIRST_LSB + 2*g]     = cls_first[g];
        assign int_stat[STAT_FIRST_LSB + 2*g + 1] = cls_rep[g];
    end

    assign irq = |int_stat;

    // registered read path
    typedef struct packed {
        logic [31:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    function automatic logic [31:0] stat_word(input logic [ECC_SYND_W-1:0] s);
        logic [31:0] w;
        w = '0;
        w[SYND_LSB +: ECC_SYND_W] = s;
        return w;
    endfunction

    always_comb begin
        rd_d = rd_q;
        if (reg_rd_en) begin
            rd_d.rdata = '0;
            if (reg_addr == a_opt) begin
                rd_d.rdata[1:0]                   = mode_q;
                rd_d.rdata[OPT_FWC_BIT]           = fwc;
                rd_d.rdata[OPT_PAT_LSB +: CHK_W]  = pat_q;
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_UE_ADDR)) begin
                rd_d.rdata = cls_addr[1];
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_UE_STAT)) begin
                rd_d.rdata = stat_word(cls_synd[1]);
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_UE_DLO)) begin
                rd_d.rdata = cls_data[1][31:0];
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_UE_DHI)) begin
                rd_d.rdata = cls_data[1][63:32];
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_CE_ADDR)) begin
                rd_d.rdata = cls_addr[0];
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_CE_STAT)) begin
                rd_d.rdata = stat_word(cls_synd[0]);
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_CE_DLO)) begin
                rd_d.rdata = cls_data[0][31:0];
            end else if (reg_addr == ERR_BASE + REG_AW'(OFS_CE_DHI)) begin
                rd_d.rdata = cls_data[0][63:32];
            end else if (reg_addr == a_int_stat) begin
                rd_d.rdata[STAT_TOP:STAT_FIRST_LSB] = int_stat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce_valid,
    input logic                  ue_valid,
    input logic                  ecc_on,
    input logic                  ce_first,
    input logic                  ce_rep,
    input logic [ECC_ADDR_W-1:0] ce_addr_q,
    input logic                  ack_wr,
    input logic [31:0]           ack_val,
    input logic                  irq,
    input logic                  fwc,
    input logic                  wr_valid,
    input logic                  opt_wr
);
    // R2
    off_no_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && !ecc_on && !ce_first) |=> !ce_first);

    // R3
    ce_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && ecc_on) |=> ce_first);

    // R5
    ce_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && ecc_on && ce_first && !(ack_wr && ack_val[3])) |=> ce_rep);

    // R5
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_first && !(ack_wr && ack_val[3])) |=> $stable(ce_addr_q));

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_valid && ecc_on) |=> irq);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && ack_val[6:3] == 4'hF && !ce_valid && !ue_valid) |=> !irq);

    // R10
    fwc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwc && wr_valid && !opt_wr) |=> !fwc);
endmodule

bind ecc_err_log ecc_err_log_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_valid  (ce_valid),
    .ue_valid  (ue_valid),
    .ecc_on    (ecc_on),
    .ce_first  (cls_first[0]),
    .ce_rep    (cls_rep[0]),
    .ce_addr_q (cls_addr[0]),
    .ack_wr    (ack_wr),
    .ack_val   (reg_wdata),
    .irq       (irq),
    .fwc       (fwc),
    .wr_valid  (wr_valid),
    .opt_wr    (opt_wr)
);

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ce_valid = 1'b0, ue_valid = 1'b0;
    logic [31:0] ce_addr = '0, ue_addr = '0;
    logic [7:0]  ce_syndrome = '0, ue_syndrome = '0;
    logic [63:0] ce_data = '0, ue_data = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  chk_in = '0;
    logic [7:0]  chk_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ecc_err_log dut_i (.*);

    typedef enum logic [1:0] {OP_WR, OP_RD, OP_CE, OP_UE} op_t;
    typedef struct packed {
        op_t         op;
        logic [11:0] addr;
        logic [31:0] val;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t TBL [NV] = '{
        '{OP_RD, 12'h200, 32'h0,        32'h0,        4'd1},  // R1
        '{OP_RD, 12'h100, 32'h0,        32'h0,        4'd1},  // R1
        '{OP_CE, 12'h000, 32'hAAAA0011, 32'h0,        4'd2},  // R2 mode 0
        '{OP_RD, 12'h200, 32'h0,        32'h0,        4'd2},
        '{OP_WR, 12'h100, 32'h2,        32'h0,        4'd2},  // R2 mode 2
        '{OP_CE, 12'h000, 32'hAAAA0011, 32'h0,        4'd2},
        '{OP_UE, 12'h000, 32'h55550022, 32'h0,        4'd2},
        '{OP_RD, 12'h200, 32'h0,        32'h0,        4'd2},
        '{OP_WR, 12'h100, 32'h00AB0001, 32'h0,        4'd9},  // R9
        '{OP_RD, 12'h100, 32'h0,        32'h00AB0001, 4'd9},
        '{OP_CE, 12'h000, 32'h12345678, 32'h0,        4'd3},  // R3
        '{OP_RD, 12'h200, 32'h0,        32'h00000008, 4'd3},
        '{OP_RD, 12'h118, 32'h0,        32'h12345678, 4'd3},
        '{OP_RD, 12'h11C, 32'h0,        32'h00007800, 4'd3},
        '{OP_RD, 12'h120, 32'h0,        32'h12345678, 4'd3},
        '{OP_RD, 12'h124, 32'h0,        32'hEDCBA987, 4'd3},
        '{OP_CE, 12'h000, 32'h0BADF00D, 32'h0,        4'd5},  // R5
        '{OP_RD, 12'h200, 32'h0,        32'h00000018, 4'd5},
        '{OP_RD, 12'h118, 32'h0,        32'h12345678, 4'd5},
        '{OP_RD, 12'h11C, 32'h0,        32'h00007800, 4'd5},
        '{OP_UE, 12'h000, 32'hCAFE0042, 32'h0,        4'd4},  // R4
        '{OP_RD, 12'h200, 32'h0,        32'h00000038, 4'd4},
        '{OP_RD, 12'h108, 32'h0,        32'hCAFE0042, 4'd4},
        '{OP_RD, 12'h10C, 32'h0,        32'h00004200, 4'd4},
        '{OP_RD, 12'h110, 32'h0,        32'hCAFE0042, 4'd4},
        '{OP_RD, 12'h114, 32'h0,        32'h3501FFBD, 4'd4},
        '{OP_UE, 12'h000, 32'h11111111, 32'h0,        4'd5},
        '{OP_RD, 12'h200, 32'h0,        32'h00000078, 4'd5},
        '{OP_RD, 12'h108, 32'h0,        32'hCAFE0042, 4'd5},
        '{OP_WR, 12'h204, 32'h00000010, 32'h0,        4'd6},  // R6
        '{OP_RD, 12'h200, 32'h0,        32'h00000068, 4'd6},
        '{OP_WR, 12'h204, 32'h00000060, 32'h0,        4'd6},
        '{OP_RD, 12'h200, 32'h0,        32'h00000008, 4'd6},
        '{OP_WR, 12'h204, 32'h00000008, 32'h0,        4'd6},
        '{OP_RD, 12'h200, 32'h0,        32'h0,        4'd6},
        '{OP_CE, 12'h000, 32'h00000101, 32'h0,        4'd6},
        '{OP_RD, 12'h118, 32'h0,        32'h00000101, 4'd6},
        '{OP_RD, 12'h11C, 32'h0,        32'h00000100, 4'd6},
        '{OP_WR, 12'h204, 32'hFFFFFFFF, 32'h0,        4'd6},
        '{OP_RD, 12'h200, 32'h0,        32'h0,        4'd6},
        '{OP_WR, 12'h100, 32'h3,        32'h0,        4'd2},  // R2 mode 3
        '{OP_UE, 12'h000, 32'h00C0FFEE, 32'h0,        4'd2},
        '{OP_RD, 12'h200, 32'h0,        32'h00000020, 4'd2},
        '{OP_WR, 12'h204, 32'h00000020, 32'h0,        4'd6},
        '{OP_RD, 12'h200, 32'h0,        32'h0,        4'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_ce(input logic [31:0] v);
        ce_valid = 1'b1; ce_addr = v; ce_syndrome = v[7:0]; ce_data = {~v, v};
    endtask

    task automatic set_ue(input logic [31:0] v);
        ue_valid = 1'b1; ue_addr = v; ue_syndrome = v[7:0]; ue_data = {~v, v};
    endtask

    task automatic event_cycle(input bit ce, input bit ue, input logic [31:0] v);
        @(negedge clk);
        if (ce) set_ce(v);
        if (ue) set_ue(v);
        @(posedge clk); #1;
        ce_valid = 1'b0; ue_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check("R1 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_WR: reg_write(TBL[i].addr, TBL[i].val);
                OP_RD: begin
                    reg_read(TBL[i].addr, rd);
                    check($sformatf("R%0d vec%0d", TBL[i].req, i), rd, TBL[i].exp);
                end
                OP_CE: event_cycle(1'b1, 1'b0, TBL[i].val);
                default: event_cycle(1'b0, 1'b1, TBL[i].val);
            endcase
        end

        // R7: interrupt follows flags one cycle later
        event_cycle(1'b1, 1'b0, 32'h00000044);
        check("R7 irq after event", {31'b0, irq}, 32'h1);
        event_cycle(1'b1, 1'b0, 32'h00000055);
        reg_write(12'h204, 32'h08);
        check("R7 irq held by repeat bit", {31'b0, irq}, 32'h1);
        reg_write(12'h204, 32'h10);
        check("R7 irq after full ack", {31'b0, irq}, 32'h0);

        // R8: simultaneous classes
        @(negedge clk);
        set_ce(32'h0000AAAA); set_ue(32'h0000BBBB);
        @(posedge clk); #1;
        ce_valid = 1'b0; ue_valid = 1'b0;
        reg_read(12'h200, rd); check("R8 both status bits", rd, 32'h28);
        reg_read(12'h118, rd); check("R8 corrected address", rd, 32'h0000AAAA);
        reg_read(12'h108, rd); check("R8 uncorrected address", rd, 32'h0000BBBB);
        reg_write(12'h204, 32'h28);

        // R11: ack and event of same class in one cycle
        event_cycle(1'b1, 1'b0, 32'h00001000);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h204; reg_wdata = 32'h08;
        set_ce(32'h00002000);
        @(posedge clk); #1;
        reg_wr_en = 1'b0; ce_valid = 1'b0;
        reg_read(12'h200, rd); check("R11 fresh first, no repeat", rd, 32'h08);
        reg_read(12'h118, rd); check("R11 new address captured", rd, 32'h00002000);
        reg_write(12'h204, 32'h78);

        // R9: reserved option bits read zero
        reg_write(12'h100, 32'hFFFFFFFF);
        reg_read(12'h100, rd); check("R9 option mask", rd, 32'h00FF0103);

        // R10: one-shot injection
        reg_write(12'h100, 32'h005A0101);
        @(negedge clk);
        chk_in = 8'h0F; wr_valid = 1'b0;
        #1 check("R10 no write, no xor", {24'b0, chk_out}, 32'h0F);
        @(negedge clk);
        wr_valid = 1'b1;
        #1 check("R10 xor on forced write", {24'b0, chk_out}, 32'h55);
        @(posedge clk); #1;
        wr_valid = 1'b0;
        reg_read(12'h100, rd); check("R10 request self-clears", rd, 32'h005A0001);
        @(negedge clk);
        wr_valid = 1'b1;
        #1 check("R10 pattern ignored when clear", {24'b0, chk_out}, 32'h0F);
        @(posedge clk); #1;
        wr_valid = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule